// File: doc/BRIEF.md
# Keyboard Input Port with Interrupt Handshake

This block is a small input port for a key source. It keeps the character code of the most recent key press in a register. The register value 0x00 means that nothing is waiting, and any nonzero value means a key is pending. The processor reads the held code through `rd_data`.

The port can release the held code in one of two ways. In polled mode, a processor read returns the code and empties the register. In interrupt mode, a pending code pulls a shared active-low request line. The port then watches the processor's active-low acknowledge line and keeps the code for the whole service. It empties the register only when the acknowledge is released.

The request is given as a drive-enable plus a level, so that several ports can share one wire with a pull-up. The acknowledge input is asynchronous and passes through a synchronizer of `SYNC_STAGES` flops.

Top module: `kbd_irq_port`

## Requirements
- R1: After reset the held code is 0x00, `rd_data` reads 0x00 and `irq_oe` is 0.
- R2: A cycle with `key_stb` high stores `key_code`, and `rd_data` shows it from the next cycle on.
- R3: In polled mode (`irq_mode`=0), a cycle with `rd_stb` high shows the held code on `rd_data` in that cycle, and the register is 0x00 from the next cycle on.
- R4: When `key_stb` and a clearing event (a polled read or an acknowledge release) fall in the same cycle, the new key code is stored and the clear is dropped.
- R5: In interrupt mode (`irq_mode`=1) with a nonzero code, `irq_oe`=1 and `irq_val`=0. With a zero code, or at any time in polled mode, `irq_oe`=0 and `irq_val`=1.
- R6: In interrupt mode, `rd_stb` leaves the held code unchanged.
- R7: While the acknowledge is held low during a service, the held code stays unchanged unless a new key arrives.
- R8: In interrupt mode, after `ack_n` has been low while a code was pending, raising `ack_n` clears the register. The clear is visible exactly `SYNC_STAGES`+1 cycles after the input rises.
- R9: An acknowledge pulse that starts and ends while no code is pending has no effect, and a key stored afterwards stays held.
- R10: A key press while a code is pending overwrites the code, and the request stays asserted.
- R11: In interrupt mode the request deasserts in the same cycle that the register becomes 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_stb | input | 1 | One-cycle strobe: a key was pressed |
| key_code | input | CODE_W | Character code of the key |
| rd_stb | input | 1 | Processor read strobe |
| irq_mode | input | 1 | 0 = polled (clear on read), 1 = interrupt (clear on acknowledge release) |
| ack_n | input | 1 | Active-low interrupt acknowledge, asynchronous |
| rd_data | output | CODE_W | Held character code |
| irq_oe | output | 1 | Drive enable for the shared request line |
| irq_val | output | 1 | Level driven on the request line (0 when requesting) |

## Verification
A wrong held register shows up directly on `rd_data` in the cycle after the stimulus. It also shows on `irq_oe` in the same cycle, because the request is decoded straight from the register. A service flag that sets or clears at the wrong time shows as a clear that comes one cycle early or late after `ack_n` rises, or as a code lost during the service. The bench therefore samples the register exactly `SYNC_STAGES` and `SYNC_STAGES`+1 cycles after the release, and every stored code is read back before the next stimulus.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
   typedef enum logic {
      MODE_POLL = 1'b0,
      MODE_IRQ  = 1'b1
   } port_mode_e;

   function automatic logic is_pending(input logic [63:0] v);
      return v != 64'd0;
   endfunction
endpackage

// File: rtl/kbd_ack_sync.sv
module kbd_ack_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_n_async,
   output logic ack_n_sync
);
   initial begin
      if (STAGES < 0 || STAGES > 4) $error("kbd_ack_sync: STAGES must be 0..4");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign ack_n_sync = ack_n_async;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else if (STAGES == 1) sh_q <= ack_n_async;
            else sh_q <= {sh_q[STAGES-2:0], ack_n_async};
         end
         assign ack_n_sync = sh_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/kbd_ack_track.sv
module kbd_ack_track (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_mode,
   input  logic pending,
   input  logic ack_n_sync,
   output logic release_p
);
   import kbd_pkg::*;

   logic in_svc_q;
   logic ack_act;

   assign ack_act   = !ack_n_sync;
   assign release_p = (irq_mode == MODE_IRQ) && in_svc_q && !ack_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        in_svc_q <= 1'b0;
      else if (irq_mode != MODE_IRQ)     in_svc_q <= 1'b0;
      else if (in_svc_q && !ack_act)     in_svc_q <= 1'b0;
      else if (ack_act && pending)       in_svc_q <= 1'b1;
   end

   // a release only ever follows an acknowledged pending code
   AST_RELEASE_AFTER_SVC: assert property (@(posedge clk) disable iff (!rst_n)
      release_p |-> ($past(ack_act) && in_svc_q)) else $error("release without service"); // R8
   AST_NO_SVC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!pending && !in_svc_q) |=> !release_p) else $error("spurious release"); // R9
endmodule

// File: rtl/kbd_code_reg.sv
module kbd_code_reg #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_stb,
   input  logic [CODE_W-1:0] key_code,
   input  logic              clr_rd,
   input  logic              clr_ack,
   output logic [CODE_W-1:0] code_q
);
   logic clr_any;
   assign clr_any = clr_rd || clr_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        code_q <= '0;
      else if (key_stb)  code_q <= key_code;
      else if (clr_any)  code_q <= '0;
   end

   AST_KEY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      key_stb |=> code_q == $past(key_code)) else $error("key not stored"); // R4
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_rd && !key_stb) |=> code_q == '0) else $error("read did not clear"); // R3
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!key_stb && !clr_any) |=> $stable(code_q)) else $error("code changed"); // R7
endmodule

// File: rtl/kbd_irq_port.sv
module kbd_irq_port #(
   parameter int CODE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_stb,
   input  logic [CODE_W-1:0] key_code,
   input  logic              rd_stb,
   input  logic              irq_mode,
   input  logic              ack_n,
   output logic [CODE_W-1:0] rd_data,
   output logic              irq_oe,
   output logic              irq_val
);
   import kbd_pkg::*;

   initial begin
      if (CODE_W < 1 || CODE_W > 64) $error("kbd_irq_port: CODE_W must be 1..64");
   end

   logic [CODE_W-1:0] code_q;
   logic              pending;
   logic              ack_n_sync;
   logic              release_p;
   logic              clr_rd;

   assign pending = is_pending(64'(code_q));
   assign clr_rd  = (irq_mode == MODE_POLL) && rd_stb;

   kbd_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .ack_n_async(ack_n), .ack_n_sync(ack_n_sync));

   kbd_ack_track u_track (
      .clk(clk), .rst_n(rst_n), .irq_mode(irq_mode), .pending(pending),
      .ack_n_sync(ack_n_sync), .release_p(release_p));

   kbd_code_reg #(.CODE_W(CODE_W)) u_reg (
      .clk(clk), .rst_n(rst_n), .key_stb(key_stb), .key_code(key_code),
      .clr_rd(clr_rd), .clr_ack(release_p), .code_q(code_q));

   assign rd_data = code_q;
   assign irq_oe  = (irq_mode == MODE_IRQ) && pending;
   assign irq_val = !irq_oe;

   AST_LOW_WHEN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      irq_oe |-> !irq_val) else $error("request driven high"); // R5
   AST_POLL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_mode == MODE_POLL) |-> !irq_oe) else $error("request in polled mode"); // R5
   AST_DROP_WITH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(irq_oe) && $past(irq_mode) && irq_mode) |-> rd_data == '0) else $error("request dropped early"); // R11
   AST_IRQ_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_mode && rd_stb && !key_stb && !release_p) |=> $stable(rd_data)) else $error("read cleared in irq mode"); // R6
endmodule

// File: tb/tb_kbd_irq_port.sv
module tb_kbd_irq_port;
   localparam int W = 8;
   localparam int S = 2;

   logic clk = 0, rst_n = 0, key_stb = 0, rd_stb = 0, irq_mode = 0, ack_n = 1;
   logic [W-1:0] key_code = '0;
   logic [W-1:0] rd_data;
   logic irq_oe, irq_val;
   int checks = 0, errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   kbd_irq_port #(.CODE_W(W), .SYNC_STAGES(S)) dut (
      .clk(clk), .rst_n(rst_n), .key_stb(key_stb), .key_code(key_code),
      .rd_stb(rd_stb), .irq_mode(irq_mode), .ack_n(ack_n),
      .rd_data(rd_data), .irq_oe(irq_oe), .irq_val(irq_val));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic press(input logic [W-1:0] c);
      key_code = c; key_stb = 1; cyc(1); key_stb = 0;
   endtask

   task automatic chk_req(input string req, input logic [W-1:0] c, input logic m);
      chk(req, {31'd0, irq_oe}, int'(m && c != 0));
      chk(req, {31'd0, irq_val}, int'(!(m && c != 0)));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      cyc(2);
      chk("R1 reset data", rd_data, 0);
      chk("R1 reset req", {31'd0, irq_oe}, 0);
      rst_n = 1; cyc(1);
      chk("R1 after release", rd_data, 0);

      // polled sweep over every nonzero code
      irq_mode = 0;
      for (int c = 1; c < (1 << W); c++) begin
         press(W'(c));
         chk("R2 stored", rd_data, c);
         chk_req("R5 polled quiet", W'(c), 1'b0);
         rd_stb = 1; #0;
         chk("R3 read value", rd_data, c);
         cyc(1); rd_stb = 0;
         chk("R3 cleared", rd_data, 0);
      end

      // key arriving with a read
      press(8'h41);
      key_code = 8'h5A; key_stb = 1; rd_stb = 1; cyc(1); key_stb = 0; rd_stb = 0;
      chk("R4 key over read", rd_data, 8'h5A);
      rd_stb = 1; cyc(1); rd_stb = 0;

      // interrupt mode sweep
      irq_mode = 1; cyc(1);
      for (int c = 1; c < (1 << W); c += 17) begin
         logic [W-1:0] v;
         v = W'(c);
         press(v);
         chk_req("R5 request", v, 1'b1);
         rd_stb = 1; cyc(1); rd_stb = 0;
         chk("R6 read keeps", rd_data, c);
         ack_n = 0; cyc(S + 3);
         chk("R7 held in service", rd_data, c);
         chk_req("R7 request held", v, 1'b1);
         ack_n = 1;
         cyc(S);
         chk("R8 not yet cleared", rd_data, c);
         cyc(1);
         chk("R8 cleared on release", rd_data, 0);
         chk_req("R11 request drops", 8'h00, 1'b1);
      end

      // overwrite while pending
      press(8'h31); press(8'h32);
      chk("R10 overwrite", rd_data, 8'h32);
      chk_req("R10 request stays", 8'h32, 1'b1);
      // overwrite during service, then key coinciding with release
      ack_n = 0; cyc(S + 2);
      press(8'h33);
      chk("R10 overwrite in service", rd_data, 8'h33);
      ack_n = 1; cyc(S);
      key_code = 8'h34; key_stb = 1; cyc(1); key_stb = 0;
      chk("R4 key over release", rd_data, 8'h34);
      chk_req("R4 request on", 8'h34, 1'b1);
      ack_n = 0; cyc(S + 2); ack_n = 1; cyc(S + 1);
      chk("R8 second release", rd_data, 0);

      // idle acknowledge pulse
      ack_n = 0; cyc(S + 2); ack_n = 1; cyc(S + 2);
      press(8'h44); cyc(S + 4);
      chk("R9 idle ack ignored", rd_data, 8'h44);
      chk_req("R9 request", 8'h44, 1'b1);

      // switching to polled mode stops the request
      irq_mode = 0; #0;
      chk_req("R5 mode off", 8'h44, 1'b0);
      ack_n = 0; cyc(S + 2); ack_n = 1; cyc(S + 2);
      chk("R8 polled ignores ack", rd_data, 8'h44);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule